// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block sets the SCL timing of an I2C master from the system clock. An 8-bit divider and a 2-bit prescale code fix the length of each half of the SCL period. The block pulls SCL low through an open-drain enable. It tells the byte engine next to it when to change SDA and when to sample SDA, using one-cycle strobes.

The high half is not counted from the moment the block releases SCL. It is counted from the first cycle in which the SCL line is seen high. A slave that holds SCL low therefore stretches the low level, and the high half still lasts its full programmed time.

With the enable input low, the master is off. The generator then sits idle with SCL released, and the divider and prescale inputs have no effect. A divider setting that is too small is flagged, and the generator stays idle while the flag is raised.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is held, scl_drive_low, drive_stb, sample_stb and cfg_err are all 0 (enable is 0).
- R2: The prescale code pre_sel selects a factor: code 0 gives 1, code 1 gives 4, code 2 gives 16 and code 3 gives 64. The half length is H = 8 + div_val × factor. scl_drive_low stays 1 for exactly H consecutive cycles in each period.
- R3: With no stretching, the time from one drive_stb to the next is 16 + 2 × div_val × factor cycles.
- R4: The high half counts from the first cycle scl_in reads 1. scl_in stays 1 for exactly H cycles. A slave holding SCL low for S extra cycles after release lengthens the low level to H + S and the period to 2H + S.
- R5: sample_stb pulses once per period for one cycle. It comes at high-phase index H/2 (integer division), where index 0 is the first cycle scl_in reads 1.
- R6: drive_stb pulses once per period for one cycle. It comes in the first cycle of each period in which scl_drive_low is 1.
- R7: cfg_err is 1 exactly when enable is 1 and div_val is below 10. While cfg_err is 1, scl_drive_low and both strobes stay 0.
- R8: With enable at 0, the generator is idle with SCL released, and cfg_err is 0 for any div_val. After enable drops, scl_drive_low is 0 from the next cycle on. After enable rises with a valid setting, the first low half begins on the next cycle, together with drive_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Master operation enable |
| div_val | input | 8 | Divider value |
| pre_sel | input | 2 | Prescale code (factor 1, 4, 16 or 64) |
| scl_in | input | 1 | Observed SCL line level |
| scl_drive_low | output | 1 | Open-drain enable: 1 pulls SCL low |
| drive_stb | output | 1 | One-cycle strobe just after SCL falls (change SDA) |
| sample_stb | output | 1 | One-cycle strobe in the middle of the high phase (sample SDA) |
| cfg_err | output | 1 | Divider below the supported minimum in master mode |

## Verification
The cycle in which a stretching slave lets go of SCL is also the first counted cycle of the high half. If the release and the count start are off by one, the high phase grows or shrinks by one cycle. To provoke this, the bench's line model holds scl_in low for 0, 1, 5 and 13 cycles after each release. It then checks three things: the high level lasts exactly H cycles, the low level lasts H + S cycles, and the sample strobe sits at index H/2 from the observed rise. A second collision comes from dropping enable in the middle of a low half. The bench checks that SCL is released on the very next cycle and not at the end of the half.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    // Phase of the SCL waveform as seen by the generator
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    // Fixed part of every half period, in system clock cycles
    localparam int HALF_BASE = 8;
    // Smallest divider accepted in master mode
    localparam int MIN_DIV   = 10;
    // Shift per prescale code step (factor 4 per step)
    localparam int PRE_STEP  = 2;

endpackage

// File: rtl/scl_half_calc.sv
module scl_half_calc
    import scl_rate_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_W = 2,
    parameter int CNT_W = 15
) (
    input  logic             enable,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PRE_W-1:0] pre_sel,
    output logic [CNT_W-1:0] half_last,
    output logic [CNT_W-1:0] half_mid,
    output logic             cfg_err
);

    localparam int NUM_PRE = 2 ** PRE_W;

    logic [CNT_W-1:0] scaled [NUM_PRE];
    logic [CNT_W-1:0] half_len;

    // One shifted copy of the divider per prescale code
    for (genvar g = 0; g < NUM_PRE; g++) begin : g_scale
        assign scaled[g] = CNT_W'(div_val) << (PRE_STEP * g);
    end

    always_comb begin
        half_len  = CNT_W'(HALF_BASE) + scaled[pre_sel];
        half_last = half_len - CNT_W'(1);
        half_mid  = half_len >> 1;
        cfg_err   = enable && (div_val < DIV_W'(MIN_DIV));
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_rate_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] half_last,
    input  logic [CNT_W-1:0] half_mid,
    output logic             scl_drive_low,
    output logic             drive_stb,
    output logic             sample_stb
);

    typedef struct packed {
        scl_phase_e       ph;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                st_d.ph  = PH_LOW;
                st_d.cnt = '0;
            end
            PH_LOW: begin
                if (st_q.cnt >= half_last) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_WAIT: begin
                // This cycle is the first high cycle once the line reads high
                if (scl_in) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = CNT_W'(1);
                end
            end
            PH_HIGH: begin
                if (st_q.cnt >= half_last) begin
                    st_d.ph  = PH_LOW;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
        endcase
        if (!run) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_drive_low = (st_q.ph == PH_LOW);
    assign drive_stb     = (st_q.ph == PH_LOW) && (st_q.cnt == '0);
    assign sample_stb    = (st_q.ph == PH_HIGH) && (st_q.cnt == half_mid);

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> drive_stb); // R6

    AST_SAMPLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (scl_in && !scl_drive_low)); // R5

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && drive_stb)); // R5

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rate_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             drive_stb,
    output logic             sample_stb,
    output logic             cfg_err
);

    localparam int CNT_W = DIV_W + PRE_STEP * ((2 ** PRE_W) - 1) + 1;

    logic [CNT_W-1:0] half_last;
    logic [CNT_W-1:0] half_mid;
    logic             run;

    scl_half_calc #(
        .DIV_W(DIV_W),
        .PRE_W(PRE_W),
        .CNT_W(CNT_W)
    ) u_calc (
        .enable   (enable),
        .div_val  (div_val),
        .pre_sel  (pre_sel),
        .half_last(half_last),
        .half_mid (half_mid),
        .cfg_err  (cfg_err)
    );

    assign run = enable && !cfg_err;

    scl_phase_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .scl_in       (scl_in),
        .half_last    (half_last),
        .half_mid     (half_mid),
        .scl_drive_low(scl_drive_low),
        .drive_stb    (drive_stb),
        .sample_stb   (sample_stb)
    );

    AST_CFG_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !scl_drive_low); // R7

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low); // R8

    AST_NO_ERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !cfg_err); // R8

endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] div_val = 8'd10;
    logic [1:0] pre_sel = 2'd0;
    logic       scl_in;
    logic       scl_drive_low, drive_stb, sample_stb, cfg_err;

    int stretch = 0;
    int rel_cnt = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    // Line model: released SCL rises after 'stretch' extra low cycles
    always @(posedge clk) begin
        if (scl_drive_low) rel_cnt <= 0;
        else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
    end
    assign scl_in = !scl_drive_low && (rel_cnt >= stretch);

    scl_rate_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val),
        .pre_sel(pre_sel), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .drive_stb(drive_stb), .sample_stb(sample_stb), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Restart with a new setting and measure one full period
    task automatic measure(input int dv, input int ps, input int s);
        int f, h, per, lo, hi, nsamp, sidx, waitc;
        f = 1 << (2 * ps);
        h = 8 + dv * f;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        div_val = 8'(dv);
        pre_sel = 2'(ps);
        stretch = s;
        enable = 1'b1;
        @(negedge clk);
        chk("R8 start", int'(drive_stb && scl_drive_low), 1);
        per = 0; lo = 0; hi = 0; nsamp = 0; sidx = -1; waitc = 0;
        do begin
            per++;
            if (scl_drive_low) lo++;
            if (scl_in) hi++;
            if (sample_stb) begin
                nsamp++;
                sidx = hi - 1;
            end
            @(negedge clk);
        end while (!drive_stb && per < 40000);
        chk("R2 low drive", lo, h);
        if (s == 0) chk("R3 period", per, 16 + 2 * dv * f);
        chk("R4 period", per, 2 * h + s);
        chk("R4 high", hi, h);
        chk("R4 low level", per - hi, h + s);
        chk("R5 count", nsamp, 1);
        chk("R5 index", sidx, h / 2);
        chk("R6 pulse", int'(scl_drive_low), 1);
    endtask

    initial begin
        #(4 * 195000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!finished) $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 drive", int'(scl_drive_low), 0);
        chk("R1 dstb", int'(drive_stb), 0);
        chk("R1 sstb", int'(sample_stb), 0);
        chk("R1 err", int'(cfg_err), 0);
        rst_n = 1'b1;

        // Off: no error for any divider, line released
        for (int d = 0; d < 12; d++) begin
            div_val = 8'(d);
            @(negedge clk);
            chk("R8 off err", int'(cfg_err), 0);
            chk("R8 off drive", int'(scl_drive_low), 0);
        end

        // Divider below minimum in master mode
        for (int d = 0; d < 12; d++) begin
            int seen;
            div_val = 8'(d);
            enable = 1'b1;
            seen = 0;
            @(negedge clk);
            chk("R7 err flag", int'(cfg_err), int'(d < 10));
            if (d < 10) begin
                for (int k = 0; k < 20; k++) begin
                    if (scl_drive_low || drive_stb || sample_stb) seen++;
                    @(negedge clk);
                end
                chk("R7 held idle", seen, 0);
            end
            enable = 1'b0;
            @(negedge clk);
        end

        // Sweep divider and prescale without stretching
        for (int ps = 0; ps < 3; ps++)
            for (int dv = 10; dv <= 20; dv++)
                measure(dv, ps, 0);
        measure(255, 0, 0);
        measure(37, 3, 0);
        measure(255, 3, 0);

        // Clock stretching by the slave
        measure(10, 0, 1);
        measure(10, 0, 5);
        measure(13, 1, 13);
        measure(20, 2, 5);

        // Disable in the middle of a low half
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        div_val = 8'd30;
        pre_sel = 2'd1;
        stretch = 0;
        enable = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8 mid low", int'(scl_drive_low), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 release", int'(scl_drive_low), 0);
        repeat (5) @(negedge clk);
        chk("R8 stays idle", int'(scl_drive_low || drive_stb || sample_stb), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule